// File: doc/BRIEF.md
# 16-bit x86 Instruction Length Decoder

This block sits after an instruction byte fetcher. It takes one byte per accepted cycle and splits the stream into instructions drawn from a small 16-bit x86 subset: the register-to-register and register-to-memory MOV forms with a ModR/M byte, the direct load into AX, the store of an immediate word to an effective address, and the move of an immediate into a word register whose number is part of the opcode. An optional operand-size prefix may come before the opcode and widens immediates from two bytes to four.

For each instruction the block reports its total length and its fields: prefix present, opcode, operand width, the ModR/M split into mode, register and r/m, the displacement and immediate with their byte counts, and an illegal flag for any opcode outside the subset. Displacements and immediates are assembled little-endian. The record is presented with a one-cycle valid pulse and is held until the next instruction completes.

Top module: `x86_len_decoder`

## Requirements
- R1: After reset the valid output is low and the next accepted byte is taken as the start of a new instruction.
- R2: The valid output rises for exactly one clock, in the cycle after the clock edge that accepts the last byte of an instruction; the record fields keep their values until the next such pulse.
- R3: A first byte of 66h is recorded as the operand-size prefix and switches immediates to four bytes; only one prefix is taken, so a 66h in the opcode position is an illegal opcode.
- R4: Opcodes B8h to BFh report the register number from opcode bits 2:0 (0=AX, 1=CX, 2=DX, 3=BX, 4=SP, 5=BP, 6=SI, 7=DI), no ModR/M, word width, and an immediate of 2 bytes (4 with prefix), low byte first.
- R5: Opcodes 88h to 8Bh take one ModR/M byte split as mode = bits 7:6, register = bits 5:3, r/m = bits 2:0; width is opcode bit 0 (0 = byte, 1 = word); they have no immediate.
- R6: The displacement byte count follows the ModR/M byte: mode 00 gives 0 bytes except r/m = 110 which gives 2 (direct address); mode 01 gives 1; mode 10 gives 2; mode 11 gives 0. It is assembled low byte first, and a one-byte displacement sits in bits 7:0 with the upper bits zero.
- R7: Opcode A1h has no ModR/M, register 0, word width and a 2-byte little-endian address reported as the displacement; the prefix does not change the address length.
- R8: Opcode C7h takes a ModR/M byte, its displacement per R6, then an immediate of 2 bytes (4 with prefix).
- R9: Any other opcode sets the illegal flag and ends the instruction at that byte: length 1, or 2 after a prefix, with all other fields zero.
- R10: Cycles with the byte-valid input low change neither the decode progress nor the outputs.
- R11: The reported length equals prefix + 1 + ModR/M present + displacement bytes + immediate bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_i | input | 8 | Instruction stream byte |
| byte_valid_i | input | 1 | byte_i is taken at this clock edge |
| dec_valid_o | output | 1 | One-cycle pulse: a decoded record is ready |
| dec_len_o | output | 4 | Total instruction length in bytes |
| dec_prefix_o | output | 1 | Operand-size prefix was present |
| dec_opcode_o | output | 8 | Opcode byte |
| dec_illegal_o | output | 1 | Opcode outside the supported subset |
| dec_wide_o | output | 1 | Word (or wider) operand, else byte |
| dec_has_modrm_o | output | 1 | A ModR/M byte was present |
| dec_mod_o | output | 2 | ModR/M mode field |
| dec_reg_o | output | 3 | Register number (ModR/M reg or opcode bits) |
| dec_rm_o | output | 3 | ModR/M r/m field |
| dec_disp_len_o | output | 2 | Displacement byte count |
| dec_disp_o | output | 16 | Displacement, little-endian assembled |
| dec_imm_len_o | output | 3 | Immediate byte count |
| dec_imm_o | output | 32 | Immediate, little-endian assembled |

## Verification
A wrong phase in the byte walker shows up as a valid pulse in the wrong cycle and a wrong length on the very instruction where it happens, and every later instruction then goes out of step. Bad field counts surface as displacement or immediate bytes landing in the wrong lane or in the wrong field, visible in the record of the same instruction. Because the reference is compared every clock, a missing or extra pulse is caught the cycle it occurs, including across idle gaps inserted between bytes.

// File: rtl/x86d_pkg.sv
package x86d_pkg;
  localparam int BYTE_W = 8;
  localparam int DISP_W = 16;
  localparam int IMM_W  = 32;
  localparam int LEN_W  = 4;
  localparam int CNT_W  = 3;
  localparam logic [BYTE_W-1:0] OPSZ_PFX = 8'h66;

  typedef enum logic [1:0] {ST_OP, ST_MODRM, ST_DISP, ST_IMM} st_e;
  typedef enum logic [1:0] {OC_ILL, OC_MODRM, OC_MOFFS, OC_REGIMM} opc_e;

  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic              prefix;
    logic [BYTE_W-1:0] opcode;
    logic              illegal;
    logic              wide;
    logic              has_modrm;
    logic [1:0]        mod;
    logic [2:0]        reg_n;
    logic [2:0]        rm;
    logic [1:0]        disp_len;
    logic [DISP_W-1:0] disp;
    logic [CNT_W-1:0]  imm_len;
    logic [IMM_W-1:0]  imm;
  } dec_rec_t;
endpackage

// File: rtl/x86d_opclass.sv
module x86d_opclass
  import x86d_pkg::*;
(
  input  logic [BYTE_W-1:0] op_i,
  input  logic              op32_i,
  output opc_e              cls_o,
  output logic              wide_o,
  output logic [2:0]        reg_o,
  output logic [CNT_W-1:0]  imm_len_o
);
  logic [CNT_W-1:0] word_len;
  assign word_len = op32_i ? CNT_W'(4) : CNT_W'(2);

  always_comb begin
    cls_o     = OC_ILL;
    wide_o    = 1'b0;
    reg_o     = '0;
    imm_len_o = '0;
    if (op_i[7:2] == 6'b100010) begin
      cls_o  = OC_MODRM;
      wide_o = op_i[0];
    end else if (op_i == 8'hC7) begin
      cls_o     = OC_MODRM;
      wide_o    = 1'b1;
      imm_len_o = word_len;
    end else if (op_i == 8'hA1) begin
      cls_o  = OC_MOFFS;
      wide_o = 1'b1;
    end else if (op_i[7:3] == 5'b10111) begin
      cls_o     = OC_REGIMM;
      wide_o    = 1'b1;
      reg_o     = op_i[2:0];
      imm_len_o = word_len;
    end
  end
endmodule

// File: rtl/x86d_disp_len.sv
module x86d_disp_len (
  input  logic [1:0] mod_i,
  input  logic [2:0] rm_i,
  output logic [1:0] len_o
);
  always_comb begin
    unique case (mod_i)
      2'b00:   len_o = (rm_i == 3'b110) ? 2'd2 : 2'd0; // direct address
      2'b01:   len_o = 2'd1;
      2'b10:   len_o = 2'd2;
      default: len_o = 2'd0;
    endcase
  end
endmodule

// File: rtl/x86_len_decoder.sv
module x86_len_decoder
  import x86d_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_valid_i,
  output logic              dec_valid_o,
  output logic [LEN_W-1:0]  dec_len_o,
  output logic              dec_prefix_o,
  output logic [BYTE_W-1:0] dec_opcode_o,
  output logic              dec_illegal_o,
  output logic              dec_wide_o,
  output logic              dec_has_modrm_o,
  output logic [1:0]        dec_mod_o,
  output logic [2:0]        dec_reg_o,
  output logic [2:0]        dec_rm_o,
  output logic [1:0]        dec_disp_len_o,
  output logic [DISP_W-1:0] dec_disp_o,
  output logic [CNT_W-1:0]  dec_imm_len_o,
  output logic [IMM_W-1:0]  dec_imm_o
);
  st_e              st_q, st_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  dec_rec_t         work_q, nxt, out_q;
  logic             valid_q, done;

  opc_e             oc_cls;
  logic             oc_wide;
  logic [2:0]       oc_reg;
  logic [CNT_W-1:0] oc_imm_len;
  logic [1:0]       dl;
  logic [1:0]       dpos;
  logic [CNT_W-1:0] ipos;

  x86d_opclass u_opclass (
    .op_i      (byte_i),
    .op32_i    (work_q.prefix),
    .cls_o     (oc_cls),
    .wide_o    (oc_wide),
    .reg_o     (oc_reg),
    .imm_len_o (oc_imm_len)
  );

  x86d_disp_len u_disp_len (
    .mod_i (byte_i[7:6]),
    .rm_i  (byte_i[2:0]),
    .len_o (dl)
  );

  assign dpos = work_q.disp_len - rem_q[1:0];
  assign ipos = work_q.imm_len - rem_q;

  always_comb begin
    nxt   = work_q;
    st_d  = st_q;
    rem_d = rem_q;
    done  = 1'b0;
    nxt.len = work_q.len + LEN_W'(1);
    unique case (st_q)
      ST_OP: begin
        if (!work_q.prefix && byte_i == OPSZ_PFX) begin
          nxt.prefix = 1'b1;
        end else begin
          nxt.opcode  = byte_i;
          nxt.wide    = oc_wide;
          nxt.reg_n   = oc_reg;
          nxt.imm_len = oc_imm_len;
          unique case (oc_cls)
            OC_MODRM: begin
              nxt.has_modrm = 1'b1;
              st_d = ST_MODRM;
            end
            OC_MOFFS: begin
              nxt.disp_len = 2'd2;
              rem_d = CNT_W'(2);
              st_d  = ST_DISP;
            end
            OC_REGIMM: begin
              rem_d = oc_imm_len;
              st_d  = ST_IMM;
            end
            default: begin
              nxt.illegal = 1'b1;
              done = 1'b1;
            end
          endcase
        end
      end
      ST_MODRM: begin
        nxt.mod      = byte_i[7:6];
        nxt.reg_n    = byte_i[5:3];
        nxt.rm       = byte_i[2:0];
        nxt.disp_len = dl;
        if (dl != 2'd0) begin
          rem_d = CNT_W'(dl);
          st_d  = ST_DISP;
        end else if (work_q.imm_len != '0) begin
          rem_d = work_q.imm_len;
          st_d  = ST_IMM;
        end else begin
          done = 1'b1;
        end
      end
      ST_DISP: begin
        nxt.disp = work_q.disp | (DISP_W'(byte_i) << (5'(dpos) << 3));
        if (rem_q == CNT_W'(1)) begin
          if (work_q.imm_len != '0) begin
            rem_d = work_q.imm_len;
            st_d  = ST_IMM;
          end else begin
            done = 1'b1;
          end
        end else begin
          rem_d = rem_q - CNT_W'(1);
        end
      end
      default: begin
        nxt.imm = work_q.imm | (IMM_W'(byte_i) << (6'(ipos) << 3));
        if (rem_q == CNT_W'(1)) done = 1'b1;
        else                    rem_d = rem_q - CNT_W'(1);
      end
    endcase
    if (done) st_d = ST_OP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_OP;
      rem_q   <= '0;
      work_q  <= '0;
      out_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= byte_valid_i && done;
      if (byte_valid_i) begin
        st_q   <= st_d;
        rem_q  <= rem_d;
        work_q <= done ? '0 : nxt;
        if (done) out_q <= nxt;
      end
    end
  end

  assign dec_valid_o     = valid_q;
  assign dec_len_o       = out_q.len;
  assign dec_prefix_o    = out_q.prefix;
  assign dec_opcode_o    = out_q.opcode;
  assign dec_illegal_o   = out_q.illegal;
  assign dec_wide_o      = out_q.wide;
  assign dec_has_modrm_o = out_q.has_modrm;
  assign dec_mod_o       = out_q.mod;
  assign dec_reg_o       = out_q.reg_n;
  assign dec_rm_o        = out_q.rm;
  assign dec_disp_len_o  = out_q.disp_len;
  assign dec_disp_o      = out_q.disp;
  assign dec_imm_len_o   = out_q.imm_len;
  assign dec_imm_o       = out_q.imm;

  // R2
  valid_after_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> $past(byte_valid_i));

  // R2
  fsm_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> (st_q == ST_OP && work_q.len == '0));

  // R11
  len_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && !dec_illegal_o) |-> dec_len_o == LEN_W'(dec_prefix_o) + LEN_W'(1)
      + LEN_W'(dec_has_modrm_o) + LEN_W'(dec_disp_len_o) + LEN_W'(dec_imm_len_o));

  // R9
  illegal_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && dec_illegal_o) |-> (dec_len_o == LEN_W'(1) + LEN_W'(dec_prefix_o)
      && !dec_has_modrm_o && dec_imm_len_o == '0 && dec_disp_len_o == 2'd0));

  // R6
  reg_mode_disp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && dec_has_modrm_o && dec_mod_o == 2'b11) |-> dec_disp_len_o == 2'd0);

  // R10
  gap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_i |=> ($stable(st_q) && $stable(rem_q) && !dec_valid_o && $stable(dec_len_o)));
endmodule

// File: tb/x86_len_decoder_bench.sv
module x86_len_decoder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  byte_i = 8'h00;
  logic        byte_valid_i = 1'b0;
  logic        dec_valid_o;
  logic [3:0]  dec_len_o;
  logic        dec_prefix_o;
  logic [7:0]  dec_opcode_o;
  logic        dec_illegal_o;
  logic        dec_wide_o;
  logic        dec_has_modrm_o;
  logic [1:0]  dec_mod_o;
  logic [2:0]  dec_reg_o;
  logic [2:0]  dec_rm_o;
  logic [1:0]  dec_disp_len_o;
  logic [15:0] dec_disp_o;
  logic [2:0]  dec_imm_len_o;
  logic [31:0] dec_imm_o;

  always #10 clk_i = ~clk_i; // 50 MHz

  x86_len_decoder u_x86_len_decoder (.*);

  typedef struct {
    int len; int pre; int op; int ill; int wide; int hm;
    int md; int rg; int rm; int dl; int disp; int il; longint imm;
  } ref_t;

  int     n_chk = 0;
  int     n_fail = 0;
  bit     exp_due = 0;
  ref_t   cur_exp, nxt_exp;
  logic [7:0] ins[$];

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic ref_t model(input logic [7:0] q[$]);
    ref_t r;
    int i;
    r = '{default: 0};
    i = 0;
    r.pre = (q[0] == 8'h66 && q.size() > 1) ? 1 : 0;
    i = r.pre;
    r.op = q[i]; i++;
    if ((r.op >= 8'h88 && r.op <= 8'h8B) || r.op == 8'hC7) begin
      r.hm = 1;
      r.wide = (r.op == 8'h88 || r.op == 8'h8A) ? 0 : 1;
      r.md = q[i] >> 6; r.rg = (q[i] >> 3) & 7; r.rm = q[i] & 7; i++;
      if (r.md == 1) r.dl = 1;
      else if (r.md == 2) r.dl = 2;
      else if (r.md == 0 && r.rm == 6) r.dl = 2;
      if (r.op == 8'hC7) r.il = r.pre ? 4 : 2;
    end else if (r.op == 8'hA1) begin
      r.wide = 1; r.dl = 2;
    end else if (r.op >= 8'hB8 && r.op <= 8'hBF) begin
      r.wide = 1; r.rg = r.op & 7; r.il = r.pre ? 4 : 2;
    end else begin
      r.ill = 1;
    end
    for (int k = 0; k < r.dl; k++) begin r.disp += int'(q[i]) << (8 * k); i++; end
    for (int k = 0; k < r.il; k++) begin r.imm += longint'(q[i]) << (8 * k); i++; end
    r.len = i;
    return r;
  endfunction

  task automatic compare();
    bit ev;
    ev = exp_due;
    exp_due = 0;
    chk("R2 valid pulse", dec_valid_o, ev);
    if (ev && dec_valid_o) begin
      chk("R11 length", dec_len_o, cur_exp.len);
      chk("R3 prefix", dec_prefix_o, cur_exp.pre);
      chk("R9 opcode", dec_opcode_o, cur_exp.op);
      chk("R9 illegal", dec_illegal_o, cur_exp.ill);
      chk("R5 wide", dec_wide_o, cur_exp.wide);
      chk("R5 has_modrm", dec_has_modrm_o, cur_exp.hm);
      chk("R5 mod", dec_mod_o, cur_exp.md);
      chk("R4 reg", dec_reg_o, cur_exp.rg);
      chk("R5 rm", dec_rm_o, cur_exp.rm);
      chk("R6 disp_len", dec_disp_len_o, cur_exp.dl);
      chk("R6 disp", dec_disp_o, cur_exp.disp);
      chk("R8 imm_len", dec_imm_len_o, cur_exp.il);
      chk("R4 imm", dec_imm_o, cur_exp.imm);
    end
  endtask

  task automatic tick(input logic v, input logic [7:0] b, input bit last);
    @(negedge clk_i);
    compare();
    byte_valid_i = v;
    byte_i = b;
    if (last) begin
      exp_due = 1;
      cur_exp = nxt_exp;
    end
  endtask

  // R10: gap idle cycles before each byte
  task automatic send(input int gap);
    nxt_exp = model(ins);
    for (int k = 0; k < ins.size(); k++) begin
      for (int g = 0; g < gap; g++) tick(1'b0, 8'hA5, 1'b0);
      tick(1'b1, ins[k], k == ins.size() - 1);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset valid", dec_valid_o, 0);
    chk("R1 reset length", dec_len_o, 0);
    rst_ni = 1'b1;
    ins = '{8'h89, 8'hD8};                 send(0); // R5 reg-reg
    ins = '{8'h8A, 8'h07};                 send(1); // R6 mod00
    ins = '{8'h89, 8'h1E, 8'h02, 8'h01};   send(0); // R6 direct address
    ins = '{8'h89, 8'h47, 8'h02};          send(2); // R6 mod01
    ins = '{8'h8B, 8'h87, 8'h34, 8'h12};   send(0); // R6 mod10
    ins = '{8'hA1, 8'h02, 8'h01};          send(0); // R7
    ins = '{8'h66, 8'hA1, 8'hCD, 8'hAB};   send(1); // R7 prefix keeps 2-byte address
    ins = '{8'hBB, 8'h34, 8'h12};          send(0); // R4
    ins = '{8'h66, 8'hB9, 8'h78, 8'h56, 8'h34, 8'h12}; send(0); // R4 R3
    ins = '{8'hC7, 8'h06, 8'h02, 8'h01, 8'h34, 8'h12}; send(3); // R8
    ins = '{8'h66, 8'hC7, 8'h41, 8'h92, 8'h78, 8'h56, 8'h34, 8'h12}; send(0); // R8
    ins = '{8'h66, 8'hC7, 8'h86, 8'h11, 8'h22, 8'hAA, 8'hBB, 8'hCC, 8'hDD}; send(0); // R11 max length
    ins = '{8'hF4};                        send(0); // R9
    ins = '{8'h00};                        send(0); // R9 back-to-back
    ins = '{8'h66, 8'h66};                 send(0); // R3 second prefix illegal
    ins = '{8'h66, 8'h88, 8'hC1};          send(2); // R5 byte width
    ins = '{8'h88, 8'h00};                 send(0); // R6 mod00 no disp
    ins = '{8'hC7, 8'hC0, 8'hEF, 8'hBE};   send(0); // R8 reg form
    ins = '{8'hBF, 8'h01, 8'h80};          send(1); // R4 DI
    for (int g = 0; g < 4; g++) tick(1'b0, 8'h89, 1'b0); // R10 idle hold
    chk("R2 held length", dec_len_o, 3);
    chk("R2 held imm", dec_imm_o, 32'h8001);
    summary();
    $finish;
  end
endmodule